// File: doc/BRIEF.md
# Serial Register Bank with Masked Status Pin

This block is a serial slave, clocked by the chip's system clock, that gives a host access to a handful of byte-wide registers. The slave oversamples the serial clock, chip select and data input through synchronizers. Each transaction begins with a command byte that holds a 7-bit register address and a direction flag. Every byte after it is a data byte for the next address in turn, so a host can write or read a run of adjacent registers without sending the address again. The address pointer wraps from 0x7F to 0x00.

The bank holds a read-only status byte that reflects four external flag inputs, and a mask byte that selects which flags drive a single status pin. It also holds a control byte whose lowest bit requests a full soft reset of the register state, and a read-only identification byte. The serial output has its own enable, so the pad can go high-impedance outside the data phase of a read.

Top module: `spi_regbank`

## Requirements
- R1: The first byte of a transaction carries the address in bits 7:1 and the direction in bit 0, where 1 means read. Data moves MSB first in SPI mode 0: it is sampled on the rising edge of `sclk` and shifted out after the falling edge.
- R2: In a write, the first data byte goes to the command address, and each further byte goes to the address one higher.
- R3: In a read, data bytes come from the command address and then from each next higher address. `mosi` is ignored during the data phase, and the pointer wraps from 0x7F to 0x00.
- R4: `miso_oe` is high only while `cs_n` is low and a read transaction is past its command byte. It stays low during every write.
- R5: Register 0x00 reads as `flags_i[3]` in bit 5, `flags_i[2]` in bit 2, `flags_i[1]` in bit 1 and `flags_i[0]` in bit 0, with all other bits 0.
- R6: Register 0x01 keeps only bits 5, 2, 1 and 0 of a written byte. Its other bits read as 0.
- R7: Within 4 clock cycles, `stat_o` equals the OR over bits 5, 2, 1 and 0 of (status AND mask). For example, mask 0x06 drives the pin from `flags_i[2]` or `flags_i[1]`.
- R8: Register 0x0B reads as the parameter `ID_VALUE`.
- R9: Writes to 0x00, to 0x0B and to unmapped addresses change nothing. Unmapped addresses read as 0x00.
- R10: If a transaction writes 1 to bit 0 of register 0x02, then when `cs_n` is deasserted the mask returns to `MASK_RST` and the control byte returns to `CTRL_RST`, whose bit 0 is 0.
- R11: Asserting `rst_n` forces `miso_oe` low at once and restores the mask to `MASK_RST`, the control byte to `CTRL_RST` and `stat_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| flags_i | input | 4 | Status flags {unlock, lock, high, low} |
| miso_o | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for the `miso_o` pad |
| stat_o | output | 1 | Masked OR of the status flags |
| ctrl_o | output | 8 | Current control byte |

## Verification
The bench builds the block with `ID_VALUE` set to 0x5C and `CTRL_RST` set to 0x3A, so a reset or soft-reset result can be told apart from an all-zero register, and with `MASK_RST` set to 0x00 and two synchronizer stages. With these values the identification byte, the restored control byte and a reset pin state are all nonzero or known patterns. One read burst starts at 0x7F, which reaches the pointer wrap. Another starts at 0x09, which crosses unmapped space into the identification byte.

// File: rtl/spi_regbank_pkg.sv
package spi_regbank_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = ADDR_W + 1;
  localparam int FLAG_W = 4;

  typedef logic [ADDR_W-1:0] reg_addr_t;
  typedef logic [DATA_W-1:0] reg_data_t;

  localparam reg_addr_t ADDR_STATUS = 7'h00;
  localparam reg_addr_t ADDR_MASK   = 7'h01;
  localparam reg_addr_t ADDR_CTRL   = 7'h02;
  localparam reg_addr_t ADDR_ID     = 7'h0B;

  // Bit positions that carry a flag in the status byte.
  localparam reg_data_t MASK_KEEP = 8'h27;

  // Map {unlock, lock, high, low} to their status byte positions.
  function automatic reg_data_t pack_status(input logic [FLAG_W-1:0] f);
    return {2'b00, f[3], 2'b00, f[2], f[1], f[0]};
  endfunction
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_rb_serial.sv
module spi_rb_serial
  import spi_regbank_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclk_s,
  input  logic      cs_s,
  input  logic      mosi_s,
  input  reg_data_t rd_data,
  output logic      cs_rise,
  output logic      wr_valid,
  output reg_data_t wr_data,
  output reg_addr_t ptr,
  output logic      miso,
  output logic      rd_phase
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic             sclk_d, cs_d;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [DATA_W-2:0] rx_q, rx_n;
  logic             data_q, data_n;
  logic             rd_q, rd_n;
  reg_addr_t        ptr_q, ptr_n;
  reg_data_t        tx_q, tx_n;
  logic             rise, fall;
  reg_data_t        byte_c;
  logic             wr_c;

  assign rise    = ~cs_s &  sclk_s & ~sclk_d;
  assign fall    = ~cs_s & ~sclk_s &  sclk_d;
  assign byte_c  = {rx_q, mosi_s};

  always_comb begin
    cnt_n  = cnt_q;
    rx_n   = rx_q;
    data_n = data_q;
    rd_n   = rd_q;
    ptr_n  = ptr_q;
    tx_n   = tx_q;
    wr_c   = 1'b0;
    if (cs_s) begin
      cnt_n  = '0;
      data_n = 1'b0;
      rd_n   = 1'b0;
    end else if (rise) begin
      rx_n  = byte_c[DATA_W-2:0];
      cnt_n = cnt_q + CNT_W'(1);
      if (cnt_q == LAST_BIT) begin
        if (!data_q) begin
          data_n = 1'b1;
          rd_n   = byte_c[0];
          ptr_n  = byte_c[DATA_W-1:1];
        end else if (!rd_q) begin
          wr_c  = 1'b1;
          ptr_n = ptr_q + reg_addr_t'(1);
        end
      end
    end else if (fall) begin
      if ((cnt_q == '0) && data_q && rd_q) begin
        tx_n  = rd_data;
        ptr_n = ptr_q + reg_addr_t'(1);
      end else begin
        tx_n = {tx_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
      cnt_q  <= '0;
      rx_q   <= '0;
      data_q <= 1'b0;
      rd_q   <= 1'b0;
      ptr_q  <= '0;
      tx_q   <= '0;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
      cnt_q  <= cnt_n;
      rx_q   <= rx_n;
      data_q <= data_n;
      rd_q   <= rd_n;
      ptr_q  <= ptr_n;
      tx_q   <= tx_n;
    end
  end

  assign cs_rise  = cs_s & ~cs_d;
  assign wr_valid = wr_c;
  assign wr_data  = byte_c;
  assign ptr      = ptr_q;
  assign miso     = tx_q[DATA_W-1];
  assign rd_phase = data_q & rd_q;
endmodule

// File: rtl/spi_rb_regs.sv
module spi_rb_regs
  import spi_regbank_pkg::*;
#(
  parameter reg_data_t ID_VALUE = 8'hC6,
  parameter reg_data_t MASK_RST = 8'h00,
  parameter reg_data_t CTRL_RST = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] flags_s,
  input  logic              wr_valid,
  input  reg_data_t         wr_data,
  input  reg_addr_t         addr,
  input  logic              cs_rise,
  output reg_data_t         rd_data,
  output reg_data_t         mask_o,
  output reg_data_t         ctrl_o,
  output logic              stat_o
);
  localparam reg_data_t MASK_DEF = MASK_RST & MASK_KEEP;

  reg_data_t mask_q, mask_n;
  reg_data_t ctrl_q, ctrl_n;
  logic      stat_q, stat_n;
  reg_data_t status;

  assign status = pack_status(flags_s);

  always_comb begin
    mask_n = mask_q;
    ctrl_n = ctrl_q;
    if (cs_rise && ctrl_q[0]) begin
      mask_n = MASK_DEF;
      ctrl_n = CTRL_RST;
    end else if (wr_valid) begin
      case (addr)
        ADDR_MASK: mask_n = wr_data & MASK_KEEP;
        ADDR_CTRL: ctrl_n = wr_data;
        default:   ;
      endcase
    end
    stat_n = |(status & mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_DEF;
      ctrl_q <= CTRL_RST;
      stat_q <= 1'b0;
    end else begin
      mask_q <= mask_n;
      ctrl_q <= ctrl_n;
      stat_q <= stat_n;
    end
  end

  always_comb begin
    case (addr)
      ADDR_STATUS: rd_data = status;
      ADDR_MASK:   rd_data = mask_q;
      ADDR_CTRL:   rd_data = ctrl_q;
      ADDR_ID:     rd_data = ID_VALUE;
      default:     rd_data = '0;
    endcase
  end

  assign mask_o = mask_q;
  assign ctrl_o = ctrl_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank #(
  parameter logic [7:0] ID_VALUE    = 8'hC6,
  parameter logic [7:0] MASK_RST    = 8'h00,
  parameter logic [7:0] CTRL_RST    = 8'h00,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       mosi,
  input  logic [3:0] flags_i,
  output logic       miso_o,
  output logic       miso_oe,
  output logic       stat_o,
  output logic [7:0] ctrl_o
);
  import spi_regbank_pkg::*;

  localparam int SYN_W = 3 + FLAG_W;

  logic [1:0]        rst_pipe;
  logic              rst_q_n;
  logic [SYN_W-1:0]  syn_q;
  logic              cs_s, sclk_s, mosi_s;
  logic [FLAG_W-1:0] flags_s;
  logic              cs_rise, wr_valid, rd_phase;
  reg_data_t         wr_data, rd_data, mask_q;
  reg_addr_t         ptr;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  spi_rb_sync #(
    .WIDTH  (SYN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL({1'b1, {(SYN_W-1){1'b0}}})
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_q_n),
    .d    ({cs_n, sclk, mosi, flags_i}),
    .q    (syn_q)
  );
  assign {cs_s, sclk_s, mosi_s, flags_s} = syn_q;

  spi_rb_serial u_serial (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .sclk_s  (sclk_s),
    .cs_s    (cs_s),
    .mosi_s  (mosi_s),
    .rd_data (rd_data),
    .cs_rise (cs_rise),
    .wr_valid(wr_valid),
    .wr_data (wr_data),
    .ptr     (ptr),
    .miso    (miso_o),
    .rd_phase(rd_phase)
  );

  spi_rb_regs #(
    .ID_VALUE(ID_VALUE),
    .MASK_RST(MASK_RST),
    .CTRL_RST(CTRL_RST)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .flags_s (flags_s),
    .wr_valid(wr_valid),
    .wr_data (wr_data),
    .addr    (ptr),
    .cs_rise (cs_rise),
    .rd_data (rd_data),
    .mask_o  (mask_q),
    .ctrl_o  (ctrl_o),
    .stat_o  (stat_o)
  );

  assign miso_oe = ~cs_n & rd_phase;
endmodule

// File: rtl/spi_regbank_chk.sv
module spi_regbank_chk
  import spi_regbank_pkg::*;
#(
  parameter reg_data_t MASK_RST = 8'h00,
  parameter reg_data_t CTRL_RST = 8'h00
) (
  input logic      clk,
  input logic      rst_n,
  input logic      cs_n,
  input logic      miso_oe,
  input logic      wr_valid,
  input reg_addr_t ptr,
  input reg_data_t mask_q,
  input reg_data_t ctrl_q,
  input logic      stat_o,
  input logic      cs_rise
);
  p_hiz_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !miso_oe);

  p_hiz_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !miso_oe);

  p_burst_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> (ptr == $past(ptr) + reg_addr_t'(1)));

  p_soft_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && ctrl_q[0]) |=> ((ctrl_q == CTRL_RST) && (mask_q == (MASK_RST & MASK_KEEP))));

  p_ro_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (ptr != ADDR_MASK) && (ptr != ADDR_CTRL)) |=> ($stable(mask_q) && $stable(ctrl_q)));

  p_stat_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> !stat_o);
endmodule

bind spi_regbank spi_regbank_chk #(
  .MASK_RST(MASK_RST),
  .CTRL_RST(CTRL_RST)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_q_n),
  .cs_n    (cs_n),
  .miso_oe (miso_oe),
  .wr_valid(wr_valid),
  .ptr     (ptr),
  .mask_q  (mask_q),
  .ctrl_q  (ctrl_o),
  .stat_o  (stat_o),
  .cs_rise (cs_rise)
);

// File: tb/test_spi_regbank.sv
`timescale 1ns/1ps
module test_spi_regbank;
  localparam logic [7:0] ID_V   = 8'h5C;
  localparam logic [7:0] CTRL_D = 8'h3A;
  localparam logic [7:0] MASK_D = 8'h00;

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, mosi;
  logic [3:0] flags_i;
  logic miso_o, miso_oe, stat_o;
  logic [7:0] ctrl_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  spi_regbank #(
    .ID_VALUE(ID_V), .MASK_RST(MASK_D), .CTRL_RST(CTRL_D), .SYNC_STAGES(2)
  ) i_spi_regbank (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .flags_i(flags_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .stat_o(stat_o), .ctrl_o(ctrl_o)
  );

  typedef struct packed {
    logic [6:0]  addr;
    logic        rd;
    logic [1:0]  n;
    logic [23:0] wd;
    logic [23:0] ex;
  } vec_t;

  // Flags held at 4'b1010 during the table: status reads 0x22.
  localparam vec_t VEC [10] = '{
    '{7'h00, 1'b1, 2'd3, 24'hA5A5A5, 24'h22003A},
    '{7'h01, 1'b0, 2'd2, 24'hFF7E00, 24'h000000},
    '{7'h00, 1'b1, 2'd3, 24'h5A5A5A, 24'h22277E},
    '{7'h00, 1'b0, 2'd1, 24'h550000, 24'h000000},
    '{7'h00, 1'b1, 2'd1, 24'hFFFFFF, 24'h220000},
    '{7'h0A, 1'b0, 2'd2, 24'h112200, 24'h000000},
    '{7'h09, 1'b1, 2'd3, 24'h000000, 24'h00005C},
    '{7'h7F, 1'b1, 2'd2, 24'hC3C3C3, 24'h002200},
    '{7'h01, 1'b0, 2'd1, 24'h060000, 24'h000000},
    '{7'h01, 1'b1, 2'd2, 24'h000000, 24'h067E00}
  };
  localparam string TAGS [10] = '{"R5", "R2", "R6", "R9", "R1", "R9", "R8", "R3", "R2", "R2"};

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, input logic exp_oe,
                          output logic [7:0] rx, inout logic ok);
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      repeat (4) @(negedge clk);
      rx[b] = miso_o;
      if (miso_oe !== exp_oe) ok = 1'b0;
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic spi_xfer(input logic [6:0] a, input logic rd, input int n,
                          input logic [23:0] wd, output logic [23:0] got);
    logic ok;
    logic [7:0] r;
    ok  = 1'b1;
    got = '0;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    spi_byte({a, rd}, 1'b0, r, ok);
    for (int k = 0; k < n; k++) begin
      spi_byte(wd[23-8*k -: 8], rd, r, ok);
      got[23-8*k -: 8] = r;
    end
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (10) @(negedge clk);
    check("R4 oe window", {7'd0, ok}, 8'd1);
    check("R4 idle hi-z", {7'd0, miso_oe}, 8'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [23:0] got;
    logic ok;
    logic [7:0] r;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0; flags_i = 4'b1010;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R11: state after reset
    check("R11 ctrl reset", ctrl_o, CTRL_D);
    check("R11 stat reset", {7'd0, stat_o}, 8'd0);
    check("R11 oe reset", {7'd0, miso_oe}, 8'd0);

    // Table-driven bursts
    for (int v = 0; v < 10; v++) begin
      spi_xfer(VEC[v].addr, VEC[v].rd, int'(VEC[v].n), VEC[v].wd, got);
      if (VEC[v].rd) begin
        for (int k = 0; k < int'(VEC[v].n); k++)
          check($sformatf("%s vec %0d byte %0d", TAGS[v], v, k),
                got[23-8*k -: 8], VEC[v].ex[23-8*k -: 8]);
      end
    end
    check("R2 ctrl after burst write", ctrl_o, 8'h7E);

    // R5: all flags set
    flags_i = 4'b1111;
    repeat (6) @(negedge clk);
    spi_xfer(7'h00, 1'b1, 1, 24'h0, got);
    check("R5 status all flags", got[23:16], 8'h27);

    // R7: masked status pin, mask is 0x06
    flags_i = 4'b0100; repeat (6) @(negedge clk);
    check("R7 lock with mask 06", {7'd0, stat_o}, 8'd1);
    flags_i = 4'b0001; repeat (6) @(negedge clk);
    check("R7 low flag masked off", {7'd0, stat_o}, 8'd0);
    flags_i = 4'b0010; repeat (6) @(negedge clk);
    check("R7 high flag with mask 06", {7'd0, stat_o}, 8'd1);
    spi_xfer(7'h01, 1'b0, 1, 24'h200000, got);
    flags_i = 4'b1000; repeat (6) @(negedge clk);
    check("R7 unlock with mask 20", {7'd0, stat_o}, 8'd1);
    flags_i = 4'b0111; repeat (6) @(negedge clk);
    check("R7 others masked off", {7'd0, stat_o}, 8'd0);

    // R10: soft reset applied at chip select release
    flags_i = 4'b0100;
    spi_xfer(7'h01, 1'b0, 2, 24'h278100, got);
    check("R10 ctrl restored", ctrl_o, CTRL_D);
    check("R10 stat after soft reset", {7'd0, stat_o}, 8'd0);
    spi_xfer(7'h01, 1'b1, 2, 24'h0, got);
    check("R10 mask readback", got[23:16], MASK_D);
    check("R10 ctrl readback", got[15:8], CTRL_D);

    // R11: reset in the middle of a read
    spi_xfer(7'h01, 1'b0, 2, 24'h275400, got);
    check("R7 stat before reset", {7'd0, stat_o}, 8'd1);
    ok = 1'b1;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    spi_byte({7'h00, 1'b1}, 1'b0, r, ok);
    for (int b = 0; b < 3; b++) begin
      repeat (4) @(negedge clk);
      sclk = 1'b1; repeat (8) @(negedge clk);
      sclk = 1'b0; repeat (4) @(negedge clk);
    end
    check("R4 oe in read data", {7'd0, miso_oe}, 8'd1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 oe drops on reset", {7'd0, miso_oe}, 8'd0);
    rst_n = 1'b1;
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    check("R11 ctrl after reset", ctrl_o, CTRL_D);
    check("R11 stat after reset", {7'd0, stat_o}, 8'd0);
    spi_xfer(7'h01, 1'b1, 1, 24'h0, got);
    check("R11 mask after reset", got[23:16], MASK_D);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule